// File: doc/BRIEF.md
# SPI Flash Transaction Engine with Shared Ring Buffer

This block is a byte-register-programmed SPI master that carries out one flash-style transaction each time software triggers it. Software loads a command byte, a packed pair of byte counts and up to eight outgoing bytes, then sets a start bit and polls it. The engine pulls chip select low and clocks out the command byte. It then clocks out the stored outgoing bytes. It then clocks out zero-valued filler bytes for as many bytes as the receive count asks for.

Outgoing and incoming data share one eight-slot ring that is never cleared. Every byte clocked after the command byte stores what came back on MISO into the ring slot that the byte's position selects, so outgoing bytes are replaced by their responses. To reach the read data, software rewinds the shared access pointer and steps past the bytes it sent. When the command byte is sent with no outgoing bytes, the engine still collects the whole receive count; no trailing byte is lost.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset, CS_n is high, SCLK and MOSI are low, the registers at offsets 0x0, 0x1, 0x2 and 0xD read 0x00, and all eight ring slots read 0x00.
- R2: The byte written at offset 0x0 is always the first byte clocked in a transaction. It never comes from the ring. Bits go out MSB first in SPI mode 0: MOSI changes while SCLK is low, and MISO is sampled on the rising edge.
- R3: Offset 0x1 holds the outgoing count in bits [3:0] and the receive count in bits [7:4]. Any count above 8 is treated as 8, so a transaction clocks 1 + send + receive bytes.
- R4: Writing 1 to bit 0 of offset 0x2 starts a transaction. That bit reads 1 while the engine is busy and returns to 0 by itself when chip select rises.
- R5: Writing 1 to bit 4 of offset 0x2 sets the ring pointer to 0, and this also works while a transaction runs.
- R6: Each write or read at offset 0xC accesses the ring slot at the pointer and then advances the pointer by one, modulo 8. The pointer reads back in bits [2:0] of offset 0xD.
- R7: After the command byte, ring slots 0 to send-1 are clocked out in order. The receive bytes that follow are clocked out as 0x00.
- R8: The MISO byte captured during the k-th byte after the command byte (k counted from 1) is written to ring slot (k-1) mod 8. All other slots keep their contents, so the read data begins at the slot equal to the send count.
- R9: With a send count of 0 and a receive count n greater than 0, exactly 1 + n bytes are clocked and all n received bytes land in slots 0 to n-1.
- R10: CS_n falls HALF_DIV clocks before the first rising SCLK edge. It rises HALF_DIV clocks after the last falling edge. SCLK toggles only while CS_n is low.
- R11: While busy, writes to offsets 0x0 and 0x1, writes to offset 0xC, and a second start request are ignored. An ignored write at 0xC does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (a read at 0xC advances the pointer) |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
On every cycle the assertions check a set of local rules: chip select is high and SCLK and MOSI rest low when idle, SCLK edges occur only inside chip select, a start always leads to busy, the pointer clears or steps by exactly one, the command and count registers hold still while busy, and ring write-back happens only inside a transaction. Only the bench's scenarios can show the end-to-end data behaviour. It sweeps every send and receive count from 0 to 8 and adds oversized counts. It checks the exact byte stream on MOSI, the resulting contents of all eight ring slots against a model of the slot overwriting, the chip-select lead and trail times, and that writes made while busy are ignored.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  // Register byte offsets; software relies on these positions.
  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNTS = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_FIFO   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  // Control byte bit positions.
  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_RWD_BIT = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_TRAIL = 2'd2
  } seq_state_e;

endpackage

// File: rtl/spi_xact_ring.sv
module spi_xact_ring #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             sw_acc,
  input  logic             sw_we,
  input  logic [7:0]       sw_wdata,
  output logic [7:0]       sw_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] eng_raddr,
  output logic [7:0]       eng_rdata,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_waddr,
  input  logic [7:0]       eng_wdata
);

  logic [DEPTH-1:0][7:0] slot_q;
  logic [PTR_W-1:0]      ptr_q;

  // Storage: engine write-back and software writes never overlap in time
  // because software writes are blocked while busy; engine wins anyway.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eng_we && eng_waddr == PTR_W'(i)) begin
          slot_q[i] <= eng_wdata;
        end else if (sw_we && ptr_q == PTR_W'(i)) begin
          slot_q[i] <= sw_wdata;
        end
      end
    end
  end

  // Shared pointer: rewind has priority over a step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_clr) begin
      ptr_q <= '0;
    end else if (sw_acc) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr       = ptr_q;
  assign sw_rdata  = slot_q[ptr_q];
  assign eng_rdata = slot_q[eng_raddr];

endmodule

// File: rtl/spi_xact_shifter.sv
module spi_xact_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       sclk_rise,
  output logic       sclk_fall
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             active_q;
  logic             sclk_q;
  logic             done_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic             phase_end;

  assign phase_end = active_q && (div_q == DIV_LAST);
  assign sclk_rise = phase_end && !sclk_q;
  assign sclk_fall = phase_end && sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      sh_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      div_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        sh_q     <= tx_byte;
        bit_q    <= '0;
        div_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (phase_end) begin
          div_q  <= '0;
          sclk_q <= !sclk_q;
          if (!sclk_q) begin
            rx_q <= {rx_q[6:0], miso};
          end else if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = active_q & sh_q[7];
  assign rx_byte   = rx_q;
  assign byte_done = done_q;

endmodule

// File: rtl/spi_xact_seq.sv
module spi_xact_seq
  import spi_xact_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int HALF_DIV = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int IDX_W = $clog2(2 * DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       opcode,
  input  logic [IDX_W-1:0] send_n,
  input  logic [IDX_W-1:0] recv_n,
  input  logic [7:0]       ring_rdata,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  output logic             busy,
  output logic             cs_n,
  output logic             start,
  output logic [7:0]       tx_byte,
  output logic [PTR_W-1:0] ring_raddr,
  output logic             ring_we,
  output logic [PTR_W-1:0] ring_waddr,
  output logic [7:0]       ring_wdata,
  output logic             xact_end
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] TRAIL_LAST = DIV_W'(HALF_DIV - 1);

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] total_q;
  logic [IDX_W-1:0] prev_idx;
  logic [DIV_W-1:0] tcnt_q;
  logic             cs_q;
  logic             more;
  logic             shift_done;

  // Byte index 0 is the command byte; index k >= 1 uses ring slot k-1.
  function automatic logic is_payload(input logic [IDX_W-1:0] slot_idx,
                                      input logic [IDX_W-1:0] n_send);
    return slot_idx < n_send;
  endfunction

  assign more       = idx_q != total_q;
  assign shift_done = (st_q == SQ_SHIFT) && byte_done;
  assign prev_idx   = idx_q - 1'b1;

  assign start      = go | (shift_done && more);
  assign ring_raddr = idx_q[PTR_W-1:0];
  assign tx_byte    = go ? opcode :
                      (is_payload(idx_q, send_n) ? ring_rdata : 8'h00);

  assign ring_we    = shift_done && (idx_q != '0);
  assign ring_waddr = prev_idx[PTR_W-1:0];
  assign ring_wdata = rx_byte;

  assign xact_end   = (st_q == SQ_TRAIL) && (tcnt_q >= TRAIL_LAST);
  assign busy       = st_q != SQ_IDLE;
  assign cs_n       = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      idx_q   <= '0;
      total_q <= '0;
      tcnt_q  <= '0;
      cs_q    <= 1'b1;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (go) begin
            st_q    <= SQ_SHIFT;
            cs_q    <= 1'b0;
            idx_q   <= '0;
            total_q <= send_n + recv_n;
          end
        end
        SQ_SHIFT: begin
          if (byte_done) begin
            if (more) begin
              idx_q <= idx_q + 1'b1;
            end else begin
              st_q   <= SQ_TRAIL;
              // one clock of the trailing half-period has already passed
              tcnt_q <= DIV_W'(1);
            end
          end
        end
        SQ_TRAIL: begin
          if (tcnt_q >= TRAIL_LAST) begin
            cs_q <= 1'b1;
            st_q <= SQ_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
  import spi_xact_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int IDX_W = $clog2(2 * DEPTH + 1);

  logic [7:0]       opcode_q;
  logic [7:0]       cnt_q;
  logic [IDX_W-1:0] send_n;
  logic [IDX_W-1:0] recv_n;
  logic             busy;
  logic             go;
  logic             ptr_clr;
  logic             fifo_wr;
  logic             fifo_acc;
  logic             wr_open;
  logic [7:0]       fifo_rdata;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] eng_raddr;
  logic [7:0]       eng_rdata;
  logic             eng_we;
  logic [PTR_W-1:0] eng_waddr;
  logic [7:0]       eng_wdata;
  logic             sh_start;
  logic [7:0]       sh_tx;
  logic [7:0]       sh_rx;
  logic             byte_done;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             xact_end;

  // Count fields saturate at the ring depth.
  function automatic logic [IDX_W-1:0] clamp_len(input logic [3:0] raw);
    return (int'(raw) > DEPTH) ? IDX_W'(DEPTH) : IDX_W'(raw);
  endfunction

  assign send_n = clamp_len(cnt_q[3:0]);
  assign recv_n = clamp_len(cnt_q[7:4]);

  // Register decode
  assign wr_open  = reg_wr && !busy;
  assign go       = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
  assign ptr_clr  = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_RWD_BIT];
  assign fifo_wr  = wr_open && (reg_addr == OFS_FIFO);
  assign fifo_acc = fifo_wr || (reg_rd && (reg_addr == OFS_FIFO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      cnt_q    <= '0;
    end else if (wr_open) begin
      if (reg_addr == OFS_OPCODE) opcode_q <= reg_wdata;
      if (reg_addr == OFS_COUNTS) cnt_q    <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    unique case (reg_addr)
      OFS_OPCODE: reg_rdata = opcode_q;
      OFS_COUNTS: reg_rdata = cnt_q;
      OFS_CTRL:   reg_rdata = {7'b0, busy};
      OFS_FIFO:   reg_rdata = fifo_rdata;
      OFS_PTR:    reg_rdata = 8'(ptr);
      default:    reg_rdata = 8'h00;
    endcase
  end

  spi_xact_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_clr   (ptr_clr),
    .sw_acc    (fifo_acc),
    .sw_we     (fifo_wr),
    .sw_wdata  (reg_wdata),
    .sw_rdata  (fifo_rdata),
    .ptr       (ptr),
    .eng_raddr (eng_raddr),
    .eng_rdata (eng_rdata),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .eng_wdata (eng_wdata)
  );

  spi_xact_seq #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .opcode     (opcode_q),
    .send_n     (send_n),
    .recv_n     (recv_n),
    .ring_rdata (eng_rdata),
    .byte_done  (byte_done),
    .rx_byte    (sh_rx),
    .busy       (busy),
    .cs_n       (spi_cs_n),
    .start      (sh_start),
    .tx_byte    (sh_tx),
    .ring_raddr (eng_raddr),
    .ring_we    (eng_we),
    .ring_waddr (eng_waddr),
    .ring_wdata (eng_wdata),
    .xact_end   (xact_end)
  );

  spi_xact_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sh_start),
    .tx_byte   (sh_tx),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_byte   (sh_rx),
    .byte_done (byte_done),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

endmodule

// File: rtl/spi_xact_engine_chk.sv
module spi_xact_engine_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             go,
  input logic             ptr_clr,
  input logic             fifo_acc,
  input logic [PTR_W-1:0] ptr,
  input logic [7:0]       opcode_q,
  input logic [7:0]       cnt_q,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             eng_we,
  input logic             xact_end
);

  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_sclk_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_edges_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise || sclk_fall) |-> !cs_n);

  p_mosi_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

  p_go_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  p_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xact_end |=> (!busy && cs_n));

  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (ptr == '0));

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_acc && !ptr_clr) |=> (ptr == $past(ptr) + 1'b1));

  p_regs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(opcode_q) && $stable(cnt_q)));

  p_capture_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (busy && !cs_n));

  p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sclk_rise, sclk_fall}));

endmodule

bind spi_xact_engine spi_xact_engine_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .cs_n      (spi_cs_n),
  .sclk      (spi_sclk),
  .mosi      (spi_mosi),
  .go        (go),
  .ptr_clr   (ptr_clr),
  .fifo_acc  (fifo_acc),
  .ptr       (ptr),
  .opcode_q  (opcode_q),
  .cnt_q     (cnt_q),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .eng_we    (eng_we),
  .xact_end  (xact_end)
);

// File: tb/spi_xact_engine_bench.sv
module spi_xact_engine_bench;

  localparam int HALF = 2;

  logic       clk;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic       reg_rd;
  logic [7:0] reg_rdata;
  logic       spi_sclk;
  logic       spi_mosi;
  logic       spi_miso;
  logic       spi_cs_n;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // Device model state
  int unsigned cyc = 0;
  int          s_byte = 0;
  int          s_bit = 0;
  int          rise_cnt = 0;
  int          cs_fall_cyc = 0;
  int          first_rise_cyc = 0;
  int          last_fall_cyc = 0;
  int          cs_rise_cyc = 0;
  logic [7:0]  mosi_sh = '0;
  logic [7:0]  mosi_log [32];
  logic [7:0]  ring_m [8];

  spi_xact_engine #(.DEPTH(8), .HALF_DIV(HALF)) u_spi_xact_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 45) ^ 8'hC3;
  endfunction

  // SPI device: drives MISO MSB first, changes on falling SCLK, logs MOSI on rising SCLK.
  initial forever begin
    logic [7:0] b;
    @(negedge spi_cs_n);
    s_byte = 0;
    s_bit = 0;
    cs_fall_cyc = cyc;
    b = resp(0);
    spi_miso = b[7];
  end

  initial forever begin
    @(posedge spi_sclk);
    if (rise_cnt == 0) first_rise_cyc = cyc;
    rise_cnt++;
    mosi_sh = {mosi_sh[6:0], spi_mosi};
    s_bit++;
    if (s_bit == 8) begin
      if (s_byte < 32) mosi_log[s_byte] = mosi_sh;
      s_byte++;
      s_bit = 0;
    end
  end

  initial forever begin
    logic [7:0] b;
    @(negedge spi_sclk);
    last_fall_cyc = cyc;
    b = resp(s_byte);
    spi_miso = b[7 - s_bit];
  end

  initial forever begin
    @(posedge spi_cs_n);
    cs_rise_cyc = cyc;
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  // mode 0: plain, mode 1: ignored writes while busy, mode 2: rewind while busy
  task automatic run_xact(input logic [7:0] op, input logic [7:0] raw, input int mode);
    int se;
    int re;
    int polls;
    string rq;
    logic [7:0] v;
    se = (raw[3:0] > 4'd8) ? 8 : int'(raw[3:0]);
    re = (raw[7:4] > 4'd8) ? 8 : int'(raw[7:4]);
    rq = (se == 0 && re > 0) ? "R9" : "R8";

    wr(4'h2, 8'h10);
    rd(4'hD, v);
    chk_eq("R5", "pointer after rewind", int'(v), 0);
    wr(4'h0, op);
    wr(4'h1, raw);
    for (int i = 0; i < se; i++) begin
      v = 8'(int'(raw) * 5 + i * 37 + 3);
      wr(4'hC, v);
      ring_m[i] = v;
    end
    rd(4'hD, v);
    chk_eq("R6", "pointer after payload writes", int'(v), se % 8);

    rise_cnt = 0;
    wr(4'h2, 8'h01);
    rd(4'h2, v);
    chk_eq("R4", "start bit reads busy", int'(v[0]), 1);
    if (mode == 1) begin
      wr(4'h0, ~op);
      wr(4'h1, 8'h00);
      wr(4'hC, 8'hEE);
      wr(4'h2, 8'h01);
      rd(4'hD, v);
      chk_eq("R11", "pointer after ignored port write", int'(v), se % 8);
    end
    if (mode == 2) begin
      wr(4'h2, 8'h10);
      rd(4'hD, v);
      chk_eq("R5", "pointer rewound while busy", int'(v), 0);
      rd(4'h2, v);
      chk_eq("R4", "busy kept across rewind", int'(v[0]), 1);
    end
    polls = 0;
    do begin
      rd(4'h2, v);
      polls++;
    end while (v[0] && polls < 4000);
    chk_eq("R4", "start bit self-cleared", int'(v[0]), 0);

    chk_eq("R10", "rising SCLK edges", rise_cnt, 8 * (1 + se + re));
    chk_eq((raw[3:0] > 4'd8 || raw[7:4] > 4'd8) ? "R3" : rq, "bytes clocked", s_byte, 1 + se + re);
    chk_eq("R2", "command byte first", int'(mosi_log[0]), int'(op));
    for (int i = 0; i < se; i++)
      chk_eq("R7", "outgoing ring byte", int'(mosi_log[1 + i]), int'(ring_m[i]));
    for (int i = 0; i < re; i++)
      chk_eq("R7", "receive filler byte", int'(mosi_log[1 + se + i]), 0);
    chk_eq("R10", "CS lead clocks", int'(first_rise_cyc) - int'(cs_fall_cyc), HALF);
    chk_eq("R10", "CS trail clocks", int'(cs_rise_cyc) - int'(last_fall_cyc), HALF);

    for (int k = 1; k <= se + re; k++) ring_m[(k - 1) % 8] = resp(k);
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v);
      chk_eq(rq, "ring slot after transaction", int'(v), int'(ring_m[i]));
    end
    rd(4'hD, v);
    chk_eq("R6", "pointer wrapped after 8 reads", int'(v), 0);
    rd(4'h0, v);
    chk_eq("R11", "command register kept", int'(v), int'(op));
    rd(4'h1, v);
    chk_eq("R11", "count register kept", int'(v), int'(raw));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n     = 1'b0;
    reg_addr  = '0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_wdata = '0;
    spi_miso  = 1'b0;
    for (int i = 0; i < 8; i++) ring_m[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk_eq("R1", "CS_n after reset", int'(spi_cs_n), 1);
    chk_eq("R1", "SCLK after reset", int'(spi_sclk), 0);
    chk_eq("R1", "MOSI after reset", int'(spi_mosi), 0);
    rd(4'h0, v); chk_eq("R1", "command register reset", int'(v), 0);
    rd(4'h1, v); chk_eq("R1", "count register reset", int'(v), 0);
    rd(4'h2, v); chk_eq("R1", "control register reset", int'(v), 0);
    rd(4'hD, v); chk_eq("R1", "pointer reset", int'(v), 0);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, v);
      chk_eq("R1", "ring slot reset", int'(v), 0);
    end
    rd(4'hD, v); chk_eq("R6", "pointer wraps after 8 reads", int'(v), 0);

    for (int s = 0; s <= 8; s++) begin
      for (int r = 0; r <= 8; r++) begin
        run_xact(8'(8'h9F ^ (s * 16 + r)), 8'((r << 4) | s), (s + r) % 3);
      end
    end

    // R3 oversized counts saturate at 8
    run_xact(8'h3B, 8'hF9, 0);
    run_xact(8'h0B, 8'hA3, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule